// File: doc/BRIEF.md
# Dispatch Group Former

This block sits between a wide decode stage and the dispatch logic of an out-of-order core. It receives decoded instructions in program order, up to `LANES` per cycle, buffers them, and packs them into fixed dispatch groups. Each group has `GEN` general slots for non-branch instructions and one extra slot that only a branch may occupy. A branch ends the group it lands in, and slots that stay empty are sent as no-ops with their valid bit low.

A formed group sits in an output register and is offered downstream only while the downstream resource check (`res_ok`) says that every rename register and execution slot the group needs is free. The group leaves as a whole, or not at all, through a valid/ready handshake. Each dispatched group carries a tag that counts up and wraps modulo the number of groups the downstream tracker can hold. A flush throws away the buffered instructions and the group waiting at the output in the same cycle.

Top module: `grp_former`

## Requirements
- R1: The branch slot (`out_br_valid`/`out_br_bits`) carries only instructions whose `in_br` flag was 1, and the general slots (`out_gen_*`, slot i at index i) carry only instructions whose flag was 0.
- R2: A group holds at most one branch, and the instruction after a branch is always the first instruction of the next group.
- R3: Valid general slots are packed from slot 0 upward with no gaps. Every slot whose valid bit is 0 is a no-op, and its bits read as all zeros.
- R4: Instructions leave in program order: the general slots in index order, then the branch slot, and groups in order. None is lost or repeated between flushes.
- R5: An input batch is lanes 0 to `in_num-1` of `in_bits`/`in_br`. It is taken whole at a clock edge where `in_ready` is 1, `in_num` is nonzero and `flush` is 0. Entries that do not fit in the current group carry over to later groups. `in_ready` is 1 after reset and after a flush.
- R6: `out_valid` is 0 whenever `res_ok` is 0. A group held back this way is not consumed and is later offered unchanged.
- R7: While `out_valid` is 1 and `out_ready` is 0, every group output and `out_tag` stay unchanged in the next cycle.
- R8: At a clock edge where `flush` is 1, the held group, all buffered instructions and that cycle's input batch are discarded. `out_valid` is 0 in the next cycle, and the `out_tag` count is kept.
- R9: `out_tag` is 0 after reset and advances by one on each dispatch (`out_valid` and `out_ready` both 1), wrapping from `NGROUPS-1` back to 0.
- R10: When all of a group's candidates are already buffered, the group takes non-branch instructions until there are four of them. If the next instruction is a branch, it goes into the branch slot. Otherwise, the next instruction begins a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard buffered and held instructions |
| in_num | input | $clog2(LANES+1) | Number of valid lanes in the batch, counted from lane 0 |
| in_br | input | LANES | Branch flag per lane |
| in_bits | input | LANES x INSTR_W | Decoded instruction per lane |
| in_ready | output | 1 | Buffer has room for a full batch |
| res_ok | input | 1 | Downstream resources for the held group are free |
| out_ready | input | 1 | Downstream accepts the group |
| out_valid | output | 1 | Group offered for dispatch |
| out_gen_valid | output | GEN | Valid per general slot (0 = no-op) |
| out_gen_bits | output | GEN x INSTR_W | General slot contents |
| out_br_valid | output | 1 | Branch slot holds a branch |
| out_br_bits | output | INSTR_W | Branch slot contents |
| out_tag | output | $clog2(NGROUPS) | Tag of the offered group |

## Verification
Directed single batches with set branch masks are used to tell the greedy close rule apart from other packings. The masks cover a branch in the middle of the batch, a branch right after four general instructions, branch-only groups, and a batch with no branches at all. Each dispatched group's general count and branch presence is compared with a partition that the bench computes. A long random run with numbered instructions mixes batch sizes, branch density, resource stalls, back-pressure and occasional flushes. It separates ordering faults, lost or duplicated instructions, slot-type errors, gating faults and tag wrap errors from correct behaviour.

// File: rtl/grpform_pkg.sv
// Package: shared instruction entry type for the group former.
// Assumes a single instruction width across the block.
package grpform_pkg;
    parameter int INSTR_W = 32;

    typedef struct packed {
        logic               br;
        logic [INSTR_W-1:0] bits;
    } instr_t;
endpackage

// File: rtl/gf_queue.sv
// gf_queue: circular buffer that takes up to LANES entries per cycle and
// gives up to PEEK entries per cycle from its head.
// Assumes DEPTH is a power of two and DEPTH >= LANES + PEEK.
module gf_queue
    import grpform_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 8,
    parameter int PEEK  = 5,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1),
    localparam int RW = $clog2(PEEK + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [NW-1:0]        wr_num,
    input  instr_t [LANES-1:0]   wr_ent,
    input  logic [RW-1:0]        rd_num,
    output instr_t [PEEK-1:0]    peek,
    output logic [CW-1:0]        level,
    output logic                 space_ok
);
    instr_t        mem [DEPTH];
    logic [PW-1:0] head;

    // Room check: a full batch must always fit.
    assign space_ok = (CW'(DEPTH) - level) >= CW'(LANES);

    // Head window read.
    always_comb begin
        for (int k = 0; k < PEEK; k++) begin
            peek[k] = mem[PW'(head + PW'(k))];
        end
    end

    // Head pointer and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            level <= '0;
        end else begin
            head  <= head + PW'(rd_num);
            level <= level + (wr_en ? CW'(wr_num) : CW'(0)) - CW'(rd_num);
        end
    end

    // Entry storage writes at the tail.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            for (int i = 0; i < LANES; i++) begin
                if (NW'(i) < wr_num) begin
                    mem[PW'(head + PW'(level) + PW'(i))] <= wr_ent[i];
                end
            end
        end
    end
endmodule

// File: rtl/gf_pick.sv
// gf_pick: combinational group packer. It scans the buffer head in order,
// fills general slots with non-branch entries and places the first branch
// in the branch slot, then closes. Empty slots come out as zeroed no-ops.
// Assumes PEEK = GEN + 1.
module gf_pick
    import grpform_pkg::*;
#(
    parameter int GEN  = 4,
    parameter int CW   = 5,
    localparam int PEEK = GEN + 1,
    localparam int RW   = $clog2(PEEK + 1)
) (
    input  instr_t [PEEK-1:0]          peek,
    input  logic [CW-1:0]              avail,
    output logic [GEN-1:0]             gen_v,
    output logic [GEN-1:0][INSTR_W-1:0] gen_d,
    output logic                       br_v,
    output logic [INSTR_W-1:0]         br_d,
    output logic [RW-1:0]              take
);
    // Greedy in-order slot assignment.
    always_comb begin
        int  ng;
        logic done;
        ng    = 0;
        done  = 1'b0;
        gen_v = '0;
        gen_d = '0;
        br_v  = 1'b0;
        br_d  = '0;
        take  = '0;
        for (int k = 0; k < PEEK; k++) begin
            if (!done && (CW'(k) < avail)) begin
                if (peek[k].br) begin
                    br_v = 1'b1;
                    br_d = peek[k].bits;
                    take = RW'(k + 1);
                    done = 1'b1;
                end else if (ng < GEN) begin
                    gen_v[ng] = 1'b1;
                    gen_d[ng] = peek[k].bits;
                    ng        = ng + 1;
                    take      = RW'(k + 1);
                end else begin
                    done = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/grp_former.sv
// grp_former: top of the dispatch group former. It buffers decoded batches,
// packs groups through gf_pick into an output register, offers a group only
// when downstream resources are free, and tags each dispatched group.
// Assumes downstream holds res_ok steady for the group it describes.
module grp_former
    import grpform_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int GEN     = 4,
    parameter int DEPTH   = 16,
    parameter int NGROUPS = 20,
    localparam int NW   = $clog2(LANES + 1),
    localparam int TW   = $clog2(NGROUPS),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PEEK = GEN + 1,
    localparam int RW   = $clog2(PEEK + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [NW-1:0]               in_num,
    input  logic [LANES-1:0]            in_br,
    input  logic [LANES-1:0][INSTR_W-1:0] in_bits,
    output logic                        in_ready,
    input  logic                        res_ok,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [GEN-1:0]              out_gen_valid,
    output logic [GEN-1:0][INSTR_W-1:0] out_gen_bits,
    output logic                        out_br_valid,
    output logic [INSTR_W-1:0]          out_br_bits,
    output logic [TW-1:0]               out_tag
);
    instr_t [LANES-1:0] wr_ent;
    instr_t [PEEK-1:0]  peek;
    logic [CW-1:0]      level;
    logic               space_ok;
    logic [RW-1:0]      take, rd_num;
    logic [GEN-1:0]     p_gen_v;
    logic [GEN-1:0][INSTR_W-1:0] p_gen_d;
    logic               p_br_v;
    logic [INSTR_W-1:0] p_br_d;
    logic               grp_v, fire, load, wr_en;

    // Pack lane inputs into entry records.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign wr_ent[i] = '{br: in_br[i], bits: in_bits[i]};
        end
    endgenerate

    assign in_ready  = space_ok;
    assign wr_en     = space_ok && (in_num != '0) && !flush;
    assign out_valid = grp_v && res_ok && !flush;
    assign fire      = out_valid && out_ready;
    assign load      = !grp_v || fire;
    assign rd_num    = (load && !flush) ? take : '0;

    gf_queue #(.DEPTH(DEPTH), .LANES(LANES), .PEEK(PEEK)) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_num(in_num), .wr_ent(wr_ent),
        .rd_num(rd_num), .peek(peek), .level(level), .space_ok(space_ok)
    );

    gf_pick #(.GEN(GEN), .CW(CW)) u_pick (
        .peek(peek), .avail(level),
        .gen_v(p_gen_v), .gen_d(p_gen_d),
        .br_v(p_br_v), .br_d(p_br_d), .take(take)
    );

    // Output group register: reload when empty or dispatched.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            grp_v         <= 1'b0;
            out_gen_valid <= '0;
            out_gen_bits  <= '0;
            out_br_valid  <= 1'b0;
            out_br_bits   <= '0;
        end else if (load) begin
            grp_v         <= (take != '0);
            out_gen_valid <= p_gen_v;
            out_gen_bits  <= p_gen_d;
            out_br_valid  <= p_br_v;
            out_br_bits   <= p_br_d;
        end
    end

    // Group tag counter, wrapping at NGROUPS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tag <= '0;
        end else if (fire) begin
            out_tag <= (out_tag == TW'(NGROUPS - 1)) ? '0 : out_tag + TW'(1);
        end
    end
endmodule

// File: rtl/gf_checker.sv
// gf_checker: temporal properties on the group former outputs, bound to
// every grp_former instance.
module gf_checker
    import grpform_pkg::*;
#(
    parameter int GEN     = 4,
    parameter int NGROUPS = 20,
    localparam int TW = $clog2(NGROUPS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        flush,
    input logic                        res_ok,
    input logic                        out_ready,
    input logic                        out_valid,
    input logic [GEN-1:0]              out_gen_valid,
    input logic [GEN-1:0][INSTR_W-1:0] out_gen_bits,
    input logic                        out_br_valid,
    input logic [INSTR_W-1:0]          out_br_bits,
    input logic [TW-1:0]               out_tag
);
    logic noop_clean;

    // All invalid slots must read as zero.
    always_comb begin
        noop_clean = out_br_valid || (out_br_bits == '0);
        for (int i = 0; i < GEN; i++) begin
            if (!out_gen_valid[i] && (out_gen_bits[i] != '0)) noop_clean = 1'b0;
        end
    end

    assert_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_gen_valid != '0) || out_br_valid);

    assert_packed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_gen_valid & (out_gen_valid + 1'b1)) == '0));

    assert_noop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> noop_clean);

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_ok |-> !out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            ($stable(out_gen_valid) && $stable(out_gen_bits) && $stable(out_br_valid)
             && $stable(out_br_bits) && $stable(out_tag)));

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    assert_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=>
            (out_tag == (($past(out_tag) == TW'(NGROUPS - 1)) ? '0 : $past(out_tag) + TW'(1))));
endmodule

bind grp_former gf_checker #(.GEN(GEN), .NGROUPS(NGROUPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .res_ok(res_ok),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_gen_valid(out_gen_valid), .out_gen_bits(out_gen_bits),
    .out_br_valid(out_br_valid), .out_br_bits(out_br_bits), .out_tag(out_tag)
);

// File: tb/sim_grp_former.sv
module sim_grp_former;
    import grpform_pkg::*;
    localparam int LANES = 8, GEN = 4, DEPTH = 16, NGROUPS = 20;
    localparam int NW = $clog2(LANES + 1), TW = $clog2(NGROUPS);

    logic clk = 0, rst_n = 0, flush = 0, res_ok = 0, out_ready = 0;
    logic [NW-1:0] in_num = '0;
    logic [LANES-1:0] in_br = '0;
    logic [LANES-1:0][INSTR_W-1:0] in_bits = '0;
    logic in_ready, out_valid, out_br_valid;
    logic [GEN-1:0] out_gen_valid;
    logic [GEN-1:0][INSTR_W-1:0] out_gen_bits;
    logic [INSTR_W-1:0] out_br_bits;
    logic [TW-1:0] out_tag;

    int errors = 0, checks = 0;
    bit finished = 0;
    logic [INSTR_W-1:0] mq_bits[$];
    bit mq_br[$];
    logic [INSTR_W-1:0] seq = 1;
    int exp_tag = 0;
    int fires = 0;
    int last_g = 0;
    bit last_b = 0;
    bit prev_stall = 0, prev_fl = 0;
    logic [GEN-1:0] h_gv;
    logic [GEN-1:0][INSTR_W-1:0] h_gd;
    logic h_bv;
    logic [INSTR_W-1:0] h_bd;
    logic [TW-1:0] h_tag;

    grp_former #(.LANES(LANES), .GEN(GEN), .DEPTH(DEPTH), .NGROUPS(NGROUPS)) u0 (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare a dispatched group with the model queue.
    task automatic check_group();
        int g;
        g = $countones(out_gen_valid);
        last_g = g;
        last_b = out_br_valid;
        chk((out_gen_valid & (out_gen_valid + 1'b1)) == '0, "R3 packed", out_gen_valid, (1 << g) - 1);
        for (int i = 0; i < GEN; i++) begin
            if (!out_gen_valid[i]) chk(out_gen_bits[i] == '0, "R3 noop zero", out_gen_bits[i], 0);
        end
        if (!out_br_valid) chk(out_br_bits == '0, "R3 noop zero br", out_br_bits, 0);
        for (int i = 0; i < g; i++) begin
            if (mq_bits.size() == 0) begin
                chk(0, "R4 extra instr", out_gen_bits[i], 0);
            end else begin
                chk(mq_br[0] == 0, "R1 branch in general slot", 1, 0);
                chk(out_gen_bits[i] == mq_bits[0], "R4 order", out_gen_bits[i], mq_bits[0]);
                void'(mq_bits.pop_front());
                void'(mq_br.pop_front());
            end
        end
        if (out_br_valid) begin
            if (mq_bits.size() == 0) begin
                chk(0, "R4 extra branch", out_br_bits, 0);
            end else begin
                chk(mq_br[0] == 1, "R1 non-branch in branch slot", 0, 1);
                chk(out_br_bits == mq_bits[0], "R4 order br", out_br_bits, mq_bits[0]);
                void'(mq_bits.pop_front());
                void'(mq_br.pop_front());
            end
        end
        chk(out_tag == TW'(exp_tag), "R9 tag", out_tag, exp_tag);
        exp_tag = (exp_tag + 1) % NGROUPS;
    endtask

    // One cycle: drive at negedge, observe, update model for the next edge.
    task automatic cycle(input int num, input logic [LANES-1:0] brm, input bit rok,
                         input bit ordy, input bit fl);
        bit fire;
        @(negedge clk);
        in_num = NW'(num);
        in_br = brm;
        for (int i = 0; i < LANES; i++) in_bits[i] = (i < num) ? seq + INSTR_W'(i) : '0;
        res_ok = rok;
        out_ready = ordy;
        flush = fl;
        #1;
        if (prev_fl) chk(out_valid == 0, "R8 flush clears group", out_valid, 0);
        if (prev_fl) chk(in_ready == 1, "R5 ready after flush", in_ready, 1);
        if (prev_stall && !prev_fl) begin
            chk(out_gen_valid == h_gv && out_gen_bits == h_gd && out_br_valid == h_bv
                && out_br_bits == h_bd && out_tag == h_tag, "R7 held stable", 0, 1);
        end
        if (!rok) chk(out_valid == 0, "R6 gated by res_ok", out_valid, 0);
        fire = out_valid && out_ready;
        if (fire) begin
            check_group();
            fires++;
        end
        prev_stall = out_valid && !out_ready && !fl;
        h_gv = out_gen_valid; h_gd = out_gen_bits; h_bv = out_br_valid;
        h_bd = out_br_bits; h_tag = out_tag;
        prev_fl = fl;
        if (fl) begin
            mq_bits.delete();
            mq_br.delete();
        end else if (in_ready && num > 0) begin
            for (int i = 0; i < num; i++) begin
                mq_bits.push_back(seq + INSTR_W'(i));
                mq_br.push_back(brm[i]);
            end
            seq = seq + INSTR_W'(num);
        end
    endtask

    // Directed batch: expected partition computed by the greedy close rule.
    task automatic run_pattern(input logic [LANES-1:0] brm);
        int eg[$];
        bit eb[$];
        int g, got, guard;
        g = 0;
        for (int i = 0; i < LANES; i++) begin
            if (brm[i]) begin eg.push_back(g); eb.push_back(1); g = 0; end
            else if (g == GEN) begin eg.push_back(GEN); eb.push_back(0); g = 1; end
            else g++;
        end
        if (g > 0) begin eg.push_back(g); eb.push_back(0); end
        cycle(LANES, brm, 0, 0, 0);
        got = 0;
        guard = 0;
        while (got < eg.size() && guard < 50) begin
            int f0;
            f0 = fires;
            cycle(0, '0, 1, 1, 0);
            if (fires != f0) begin
                chk(last_g == eg[got], "R10 general count", last_g, eg[got]);
                chk(last_b == eb[got], "R2 branch closes group", last_b, eb[got]);
                got++;
            end
            guard++;
        end
        chk(got == eg.size(), "R5 all groups dispatched", got, eg.size());
        chk(mq_bits.size() == 0, "R4 nothing left", mq_bits.size(), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(out_valid == 0, "R9 reset valid", out_valid, 0);
        chk(in_ready == 1, "R5 reset ready", in_ready, 1);
        chk(out_tag == 0, "R9 reset tag", out_tag, 0);

        run_pattern(8'b0000_0100);
        run_pattern(8'b1101_0000);
        run_pattern(8'b0000_0000);
        run_pattern(8'b1111_1111);
        run_pattern(8'b0010_0001);

        // R6: group held while resources busy, then offered unchanged.
        cycle(3, 8'b0, 0, 1, 0);
        repeat (5) cycle(0, '0, 0, 1, 0);
        repeat (3) cycle(0, '0, 1, 1, 0);
        chk(mq_bits.size() == 0, "R6 held group later dispatched", mq_bits.size(), 0);

        // R8: flush drops a held group and the buffer, new batch comes out first.
        cycle(8, 8'b0, 0, 0, 0);
        cycle(0, '0, 0, 0, 1);
        cycle(2, 8'b10, 1, 1, 0);
        repeat (4) cycle(0, '0, 1, 1, 0);
        chk(mq_bits.size() == 0, "R8 post-flush batch dispatched", mq_bits.size(), 0);

        // Random mix.
        for (int c = 0; c < 3000; c++) begin
            int n;
            logic [LANES-1:0] bm;
            n = $urandom_range(0, LANES);
            for (int i = 0; i < LANES; i++) bm[i] = ($urandom_range(0, 3) == 0);
            cycle(n, bm, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                  $urandom_range(0, 63) == 0);
        end
        for (int c = 0; c < 40; c++) cycle(0, '0, 1, 1, 0);
        chk(mq_bits.size() == 0, "R5 drained after random", mq_bits.size(), 0);
        chk(fires > NGROUPS, "R9 tag wrapped", fires, NGROUPS);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule